// File: doc/BRIEF.md
# IEEE 802.15.4 Immediate Acknowledgement Responder

This block sits between a receiver and the MAC layer above it. It watches every frame the receiver hands over as a byte stream and decides, once the frame has ended, whether the frame is kept. It also decides whether the sender asked for an immediate acknowledgement. The receiver has already done the CRC work and reports only a pass/fail flag with the end-of-frame strobe.

When an acknowledgement is due, the block streams a ready-made acknowledgement PHY payload to the transmit path. That payload is a length byte followed by a three-byte MAC body that echoes the received sequence number. The received frame is handed up only after the transmit path reports that the acknowledgement is finished. Frames with a bad CRC or an impossible length are dropped without any trace at the outputs.

The received byte stream and both outgoing streams use valid/ready. The receive side is stalled (`rx_ready` low) for as long as a frame is being acknowledged or is waiting to be handed up. While `ack_valid` is high and `ack_ready` is low, the acknowledgement byte on offer does not change. While `dlv_valid` is high and `dlv_ready` is low, the delivered fields do not change. A transfer happens on a rising edge where valid and ready are both high.

Top module: `ack_responder`

## Requirements
- R1: After reset, `ack_valid` and `dlv_valid` are low, `rx_ready` is high and `drop_cnt` is zero.
- R2: Within a frame, the first accepted byte is the length field L, and the next byte is the first frame-control byte. The byte accepted fourth (index 3) is the sequence number, and the byte at index L+1 is the link-quality value. `rx_ready` is low in any cycle where `rx_end` is high and while an acknowledgement or delivery is pending.
- R3: An acknowledgement is requested when bit 5 (mask 0x20) of the first frame-control byte is set. If it is requested, `rx_crc_ok` is high and the length is valid, then from the cycle after `rx_end` the block offers four bytes: 0x05, 0x02, 0x00 and the sequence number. `ack_last` is high only with the fourth byte.
- R4: While `ack_valid` is high and `ack_ready` is low, `ack_valid` stays high and `ack_data` holds its value.
- R5: An acknowledged frame is offered upward only in the cycle after `ack_done` is seen. `dlv_len` is L-2, `dlv_lqi` is the link-quality byte and `dlv_seq` is the sequence number. `ack_valid` and `dlv_valid` are never high together.
- R6: A valid frame without the request bit is offered upward in the cycle after `rx_end`, and no acknowledgement is sent.
- R7: A frame ending with `rx_crc_ok` low produces no acknowledgement and no delivery.
- R8: A frame with L of at least MAX_FRAME+2 (129 by default), or with L below 3, is discarded in the same way. L = 128 is accepted.
- R9: If `ack_busy` is high when the frame ends, the request bit is disregarded. The frame is delivered at once and no acknowledgement is sent.
- R10: While `dlv_valid` is high and `dlv_ready` is low, `dlv_valid` stays high and `dlv_len`, `dlv_lqi` and `dlv_seq` hold their values.
- R11: An `rx_end` arriving while an acknowledgement or delivery is pending leaves the pending work untouched. Each such `rx_end` raises `drop_cnt` by one, and the count saturates at its all-ones value (7 with the default width of 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Block accepts a received byte |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End-of-frame strobe |
| rx_crc_ok | input | 1 | CRC check result, sampled with `rx_end` |
| ack_busy | input | 1 | Transmit path cannot take an acknowledgement now |
| ack_valid | output | 1 | Acknowledgement byte valid |
| ack_ready | input | 1 | Transmit path takes the byte |
| ack_data | output | 8 | Acknowledgement byte |
| ack_last | output | 1 | Final acknowledgement byte |
| ack_done | input | 1 | Transmit path finished sending the acknowledgement |
| dlv_valid | output | 1 | Received frame summary valid |
| dlv_ready | input | 1 | Upper layer takes the summary |
| dlv_len | output | 8 | Frame length without FCS |
| dlv_lqi | output | 8 | Link-quality value |
| dlv_seq | output | 8 | Sequence number |
| drop_cnt | output | DROP_W | Saturating count of ignored frame ends |

## Verification
Every result is due a fixed number of cycles after its cause. The first acknowledgement byte and any direct delivery appear in the cycle after `rx_end`. A delivery that follows an acknowledgement appears in the cycle after `ack_done`. `drop_cnt` moves in the cycle after an ignored `rx_end`.

The bench drives inputs on falling edges and samples outputs shortly after them. A transfer on either output stream is therefore judged in the cycle where it completes, and each transfer is compared in order against the scoreboard queues. A delivery seen while an acknowledgement is still outstanding is flagged, as is any output for which nothing is queued. Discard cases are confirmed by idle outputs a few cycles after the frame ends.

// File: rtl/ack_responder_pkg.sv
package ack_responder_pkg;
  localparam int BYTE_W        = 8;
  localparam int FCS_BYTES     = 2;
  localparam int ACK_MAC_BYTES = 3;
  localparam int ACK_REQ_BIT   = 5;
  localparam int SEQ_INDEX     = 3;
  localparam logic [BYTE_W-1:0] ACK_FC_LO = 8'h02;
  localparam logic [BYTE_W-1:0] ACK_FC_HI = 8'h00;

  typedef enum logic [1:0] {
    ST_RX       = 2'd0,
    ST_ACK_SEND = 2'd1,
    ST_ACK_WAIT = 2'd2,
    ST_DELIVER  = 2'd3
  } resp_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] len;
    logic [BYTE_W-1:0] fc_lo;
    logic [BYTE_W-1:0] seq;
    logic [BYTE_W-1:0] lqi;
  } frame_info_t;
endpackage

// File: rtl/rx_field_capture.sv
module rx_field_capture
  import ack_responder_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_fire,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              clear,
  output frame_info_t       info
);
  localparam int CNT_W = BYTE_W + 1;

  logic [CNT_W-1:0] pos_q;
  frame_info_t      info_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos_q  <= '0;
      info_q <= '0;
    end else if (byte_fire) begin
      if (pos_q == '0) info_q.len <= byte_in;
      if (pos_q == CNT_W'(1)) info_q.fc_lo <= byte_in;
      if (pos_q == CNT_W'(SEQ_INDEX)) info_q.seq <= byte_in;
      if (pos_q != '0 && pos_q == ({1'b0, info_q.len} + CNT_W'(1)))
        info_q.lqi <= byte_in;
      if (pos_q != '1) pos_q <= pos_q + CNT_W'(1);
    end
  end

  assign info = info_q;

  a_r2_len_first: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && !clear && pos_q == '0) |=> info.len == $past(byte_in));
endmodule

// File: rtl/ack_frame_tx.sv
module ack_frame_tx
  import ack_responder_pkg::*;
#(
  parameter int ACK_BYTES = ACK_MAC_BYTES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] seq_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              finished
);
  localparam int IDX_W = $clog2(ACK_BYTES);
  localparam logic [BYTE_W-1:0] ACK_LEN = BYTE_W'(ACK_MAC_BYTES + FCS_BYTES);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] seq_q;

  assign out_last = active_q && (idx_q == IDX_W'(ACK_BYTES - 1));
  assign finished = out_valid && out_ready && out_last;
  assign out_valid = active_q;

  always_comb begin
    case (idx_q)
      IDX_W'(0): out_data = ACK_LEN;
      IDX_W'(1): out_data = ACK_FC_LO;
      IDX_W'(2): out_data = ACK_FC_HI;
      default:   out_data = seq_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      seq_q    <= '0;
    end else if (start && !active_q) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      seq_q    <= seq_in;
    end else if (active_q && out_ready) begin
      if (out_last) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r3_len_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data == ACK_LEN);
endmodule

// File: rtl/sat_drop_counter.sv
module sat_drop_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (bump && cnt_q != '1) cnt_q <= cnt_q + W'(1);
  end

  assign count = cnt_q;

  a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && count == '1) |=> count == '1);
  a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && count != '1) |=> count == $past(count) + W'(1));
endmodule

// File: rtl/ack_responder.sv
module ack_responder
  import ack_responder_pkg::*;
#(
  parameter int MAX_FRAME = 127,
  parameter int DROP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_end,
  input  logic              rx_crc_ok,
  input  logic              ack_busy,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic [7:0]        ack_data,
  output logic              ack_last,
  input  logic              ack_done,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [7:0]        dlv_len,
  output logic [7:0]        dlv_lqi,
  output logic [7:0]        dlv_seq,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int LEN_LIMIT = MAX_FRAME + FCS_BYTES;
  localparam int MIN_LEN   = ACK_MAC_BYTES;

  resp_state_e state_q;
  frame_info_t cur_info;
  frame_info_t held_q;
  logic        byte_fire;
  logic        frame_end;
  logic        frame_ok;
  logic        want_ack;
  logic        ack_start;
  logic        ack_finished;

  assign rx_ready  = (state_q == ST_RX) && !rx_end;
  assign byte_fire = rx_valid && rx_ready;
  assign frame_end = (state_q == ST_RX) && rx_end;

  rx_field_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_fire (byte_fire),
    .byte_in   (rx_data),
    .clear     (frame_end),
    .info      (cur_info)
  );

  assign frame_ok = rx_crc_ok
                 && (int'(cur_info.len) >= MIN_LEN)
                 && (int'(cur_info.len) < LEN_LIMIT);
  assign want_ack  = cur_info.fc_lo[ACK_REQ_BIT];
  assign ack_start = frame_end && frame_ok && want_ack && !ack_busy;

  ack_frame_tx u_ack_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ack_start),
    .seq_in    (cur_info.seq),
    .out_valid (ack_valid),
    .out_ready (ack_ready),
    .out_data  (ack_data),
    .out_last  (ack_last),
    .finished  (ack_finished)
  );

  sat_drop_counter #(.W(DROP_W)) u_drops (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (rx_end && (state_q != ST_RX)),
    .count (drop_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RX;
      held_q  <= '0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (frame_end && frame_ok) begin
            held_q  <= cur_info;
            state_q <= ack_start ? ST_ACK_SEND : ST_DELIVER;
          end
        end
        ST_ACK_SEND: if (ack_finished) state_q <= ST_ACK_WAIT;
        ST_ACK_WAIT: if (ack_done) state_q <= ST_DELIVER;
        default:     if (dlv_ready) state_q <= ST_RX;
      endcase
    end
  end

  assign dlv_valid = (state_q == ST_DELIVER);
  assign dlv_len   = held_q.len - 8'(FCS_BYTES);
  assign dlv_lqi   = held_q.lqi;
  assign dlv_seq   = held_q.seq;

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && dlv_valid));
  a_r10_dlv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=>
      (dlv_valid && $stable(dlv_len) && $stable(dlv_lqi) && $stable(dlv_seq)));
  a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid || dlv_valid) |-> !rx_ready);
  a_r7_crc_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && state_q == ST_RX && !rx_crc_ok) |=> (!ack_valid && !dlv_valid));
endmodule

// File: tb/ack_responder_bench.sv
`timescale 1ns/1ps
module ack_responder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_end = 1'b0, rx_crc_ok = 1'b0, ack_busy = 1'b0;
  logic [7:0] rx_data = '0;
  logic ack_ready = 1'b1, ack_done = 1'b0, dlv_ready = 1'b1;
  logic rx_ready, ack_valid, ack_last, dlv_valid;
  logic [7:0] ack_data, dlv_len, dlv_lqi, dlv_seq;
  logic [2:0] drop_cnt;

  int checks = 0, errors = 0;
  int ack_mode = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit ack_pending = 0;
  bit finished = 0;
  logic [8:0]  exp_ack[$];
  logic [23:0] exp_dlv[$];

  always #2 clk = ~clk;

  ack_responder u_ack_responder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .ack_busy(ack_busy),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_data(ack_data),
    .ack_last(ack_last), .ack_done(ack_done), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_len(dlv_len), .dlv_lqi(dlv_lqi),
    .dlv_seq(dlv_seq), .drop_cnt(drop_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Transmit-side and delivery monitor (scoreboard)
  always @(negedge clk) begin
    cyc++;
    case (ack_mode)
      0: ack_ready = 1'b1;
      1: ack_ready = cyc[0];
      default: ack_ready = 1'b0;
    endcase
    ack_done = (done_cnt == 1);
    if (done_cnt != 0) done_cnt--;
    if (ack_done) ack_pending = 0;
    #1;
    if (ack_valid && ack_ready) begin
      if (exp_ack.size() == 0) chk(0, "R3 unexpected ack byte", {23'd0, ack_last, ack_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_ack.pop_front();
        chk({ack_last, ack_data} == e, "R3 ack byte", {23'd0, ack_last, ack_data}, {23'd0, e});
      end
      if (ack_last) done_cnt = 3;
    end
    if (dlv_valid) chk(!ack_pending, "R5 delivery before ack_done", 1, 0);
    if (dlv_valid && dlv_ready) begin
      if (exp_dlv.size() == 0) chk(0, "R6 unexpected delivery", {8'd0, dlv_len, dlv_lqi, dlv_seq}, 0);
      else begin
        logic [23:0] d;
        d = exp_dlv.pop_front();
        chk({dlv_len, dlv_lqi, dlv_seq} == d, "R5 delivered fields",
            {8'd0, dlv_len, dlv_lqi, dlv_seq}, {8'd0, d});
      end
    end
  end

  task automatic put_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    forever begin
      #1;
      if (rx_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic pulse_end(input bit crc);
    rx_end = 1'b1; rx_crc_ok = crc;
    @(negedge clk);
    rx_end = 1'b0; rx_crc_ok = 1'b0;
  endtask

  // Driver: sends bytes, predicts outcome, pushes expectations (R2 layout)
  task automatic send_frame(input int len, input logic [7:0] fc, input logic [7:0] seq,
                            input logic [7:0] lqi, input bit crc);
    bit bad, ack;
    @(negedge clk);
    for (int i = 0; i <= len + 1; i++) begin
      logic [7:0] b;
      if (i == 0) b = 8'(len);
      else if (i == len + 1) b = lqi;
      else if (i == 1) b = fc;
      else if (i == 2) b = 8'h00;
      else if (i == 3) b = seq;
      else b = 8'(i * 7);
      put_byte(b);
    end
    bad = !crc || len >= 129 || len < 3;
    ack = !bad && fc[5] && !ack_busy;
    if (ack) begin
      exp_ack.push_back({1'b0, 8'h05});
      exp_ack.push_back({1'b0, 8'h02});
      exp_ack.push_back({1'b0, 8'h00});
      exp_ack.push_back({1'b1, seq});
      ack_pending = 1;
    end
    if (!bad) exp_dlv.push_back({8'(len - 2), lqi, seq});
    pulse_end(crc);
  endtask

  task automatic drain();
    for (int k = 0; k < 200; k++) begin
      if (exp_ack.size() == 0 && exp_dlv.size() == 0 && !dlv_valid) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check(input string req, input logic [2:0] drops);
    repeat (5) @(negedge clk);
    #1;
    chk(!ack_valid && !dlv_valid, req, {ack_valid, dlv_valid}, 0);
    chk(drop_cnt == drops, req, drop_cnt, drops);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!ack_valid, "R1 ack_valid", ack_valid, 0);
    chk(!dlv_valid, "R1 dlv_valid", dlv_valid, 0);
    chk(drop_cnt == 0, "R1 drop_cnt", drop_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rx_ready, "R1 rx_ready", rx_ready, 1);

    // R3/R5: ack requested, free-flowing transmit path
    send_frame(10, 8'h61, 8'h3c, 8'hd5, 1);
    #1;
    chk(ack_valid && ack_data == 8'h05, "R3 first ack byte next cycle", ack_data, 8'h05);
    chk(!rx_ready, "R2 stalled during ack", rx_ready, 0);
    drain();

    // R4: back-pressure on acknowledgement
    ack_mode = 1;
    send_frame(20, 8'h21, 8'h99, 8'h40, 1);
    drain();
    ack_mode = 0;

    // R6: no request bit
    send_frame(5, 8'h41, 8'h11, 8'h77, 1);
    #1;
    chk(dlv_valid && !ack_valid, "R6 immediate delivery", {ack_valid, dlv_valid}, 1);
    drain();

    // R7: CRC failure
    send_frame(8, 8'h21, 8'h22, 8'h33, 0);
    idle_check("R7 crc discard", 0);

    // R8: length bounds
    send_frame(129, 8'h21, 8'h44, 8'h55, 1);
    idle_check("R8 oversize discard", 0);
    send_frame(2, 8'h21, 8'h45, 8'h56, 1);
    idle_check("R8 short discard", 0);
    send_frame(128, 8'h21, 8'h46, 8'h57, 1);
    drain();

    // R9: transmit path busy
    ack_busy = 1'b1;
    send_frame(12, 8'h21, 8'h5a, 8'h66, 1);
    #1;
    chk(dlv_valid && !ack_valid, "R9 deliver without ack", {ack_valid, dlv_valid}, 1);
    drain();
    ack_busy = 1'b0;

    // R11: frame end during ack is ignored, R4 hold
    ack_mode = 2;
    send_frame(9, 8'h23, 8'h7e, 8'h12, 1);
    @(negedge clk);
    pulse_end(1);
    #1;
    chk(drop_cnt == 1, "R11 drop counted", drop_cnt, 1);
    chk(ack_valid && ack_data == 8'h05, "R4 ack held", ack_data, 8'h05);
    ack_mode = 0;
    drain();

    // R10/R11: held delivery and saturation
    dlv_ready = 1'b0;
    send_frame(6, 8'h01, 8'h0f, 8'hee, 1);
    for (int k = 0; k < 8; k++) pulse_end(1);
    #1;
    chk(drop_cnt == 3'd7, "R11 saturation", drop_cnt, 7);
    chk(dlv_valid && dlv_len == 8'd4 && dlv_seq == 8'h0f, "R10 delivery held",
        {dlv_valid, dlv_len, dlv_seq}, {1'b1, 8'd4, 8'h0f});
    chk(!rx_ready, "R10 receive stalled", rx_ready, 0);
    @(negedge clk);
    dlv_ready = 1'b1;
    drain();

    chk(exp_ack.size() == 0, "R3 leftover ack bytes", exp_ack.size(), 0);
    chk(exp_dlv.size() == 0, "R5 leftover deliveries", exp_dlv.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule